// File: doc/BRIEF.md
# Decode-Stage Hazard Controller

This block sits between the fetch and decode stages of a five-stage in-order pipeline. It holds the program counter and the fetch/decode pipeline register. It watches for one pipeline hazard and one control hazard. The first is a load in execute whose destination register is a source of the instruction in decode. Forwarding cannot cover that case, so the block freezes the program counter and the fetch/decode register for one cycle. In the same cycle it zeroes the control word that enters the decode/execute register, which sends a bubble down the pipe.

Branch-if-equal is resolved in decode. The block compares the two operand values that the register file supplies and adds the word-scaled, sign-extended offset to the sequential address. Fetch always continues on the not-taken path. When the branch is taken, the block loads the program counter with the target and clears the instruction that was just fetched, which leaves a no-op in decode. If a stall and a taken branch appear in the same cycle, the stall has priority. The branch is then evaluated again one cycle later, once the load value is available.

Top module: `decode_hazard_ctl`

## Requirements
- R1: While rst_n is low at a clock edge, pc, ifid_instr and ifid_seq_pc are all loaded with zero (the default reset address).
- R2: With no stall and no taken branch, each clock edge sets pc to pc+4, ifid_instr to imem_instr and ifid_seq_pc to the old pc+4.
- R3: stall is high exactly when ex_mem_read is 1 and ex_dst_reg equals either source field of ifid_instr (bits 25:21 or bits 20:16).
- R4: A cycle with stall high leaves pc, ifid_instr and ifid_seq_pc unchanged at the next edge.
- R5: id_ctrl_out equals dec_ctrl_in when stall is low and is all zeros when stall is high.
- R6: An instruction in decode with opcode bits 31:26 equal to 000100 and equal operand values (src_a_val == src_b_val) raises br_taken. br_target is ifid_seq_pc plus the sign-extended bits 15:0 times 4, computed modulo 2^32, so negative offsets are handled.
- R7: flush follows br_taken. At the edge after a taken branch, pc becomes br_target and ifid_instr becomes all zeros.
- R8: A branch opcode with unequal operands, or any other opcode with equal operands, causes no redirect and no flush.
- R9: When stall and a branch condition are both true in a cycle, stall wins: br_taken and flush stay low and nothing moves. The branch is evaluated again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_instr | input | 32 | Instruction fetched at pc |
| ex_mem_read | input | 1 | Instruction in execute is a load |
| ex_dst_reg | input | 5 | Destination register of the instruction in execute |
| src_a_val | input | 32 | Register value read for source field 25:21 |
| src_b_val | input | 32 | Register value read for source field 20:16 |
| dec_ctrl_in | input | 9 | Control word from the main decoder |
| pc | output | 32 | Program counter (fetch address) |
| ifid_instr | output | 32 | Instruction held in decode |
| ifid_seq_pc | output | 32 | Sequential address (fetch pc + 4) of the decode instruction |
| id_ctrl_out | output | 9 | Control word entering decode/execute, zero on a bubble |
| stall | output | 1 | Load-use stall in progress |
| flush | output | 1 | Squash the fetched instruction |
| br_taken | output | 1 | Branch in decode is taken |
| br_target | output | 32 | Computed branch target |

## Verification
The stall detector is swept over every combination of load flag, execute destination and the two decode source fields in a small register range. This separates matches on the first source field, matches on the second, matches on both, and the cases where the load flag is clear. The branch path uses positive, zero, negative and extreme offsets, each with equal and unequal operands. This separates the sign extension and scaling of the target from the comparison. A second branch opcode with equal operands shows that the opcode is decoded. A collision between a load-use stall and a taken branch checks that the stall takes priority and that the redirect follows one cycle later.

// File: rtl/decode_hazard_pkg.sv
// Shared constants and the instruction field layout for the decode hazard
// controller. Assumes a fixed 32-bit instruction word.
package decode_hazard_pkg;

    localparam int INSTR_W = 32;
    localparam int OP_W    = 6;
    localparam int RIDX_W  = 5;
    localparam int IMM_W   = 16;

    localparam logic [OP_W-1:0] OP_BR_EQ = 6'b000100;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [RIDX_W-1:0] src_a;
        logic [RIDX_W-1:0] src_b;
        logic [IMM_W-1:0]  imm;
    } instr_fields_t;

endpackage

// File: rtl/dh_load_use_detect.sv
// Load-use detector: flags the case where the instruction in execute is a
// load and its destination is one of the two sources of the decode
// instruction. Purely combinational.
module dh_load_use_detect #(
    parameter int RIDX_W = 5
) (
    input  logic              ld_in_ex,
    input  logic [RIDX_W-1:0] ld_dst,
    input  logic [RIDX_W-1:0] use_a,
    input  logic [RIDX_W-1:0] use_b,
    output logic              hazard
);

    // compare the load destination against both source fields
    always_comb begin
        hazard = ld_in_ex && ((ld_dst == use_a) || (ld_dst == use_b));
    end

endmodule

// File: rtl/dh_branch_resolve.sv
// Early branch resolver: equality compare of two operand values and target
// adder (sequential address + sign-extended offset * 4). Assumes
// ADDR_W >= IMM_W + 2. The taken flag is masked by an external block signal.
module dh_branch_resolve #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              is_branch,
    input  logic              block,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [ADDR_W-1:0] seq_addr,
    input  logic [IMM_W-1:0]  offset,
    output logic              taken,
    output logic [ADDR_W-1:0] target
);

    localparam int EXT_W = ADDR_W - IMM_W - 2;

    logic [DATA_W-1:0] diff_bits;
    logic [ADDR_W-1:0] scaled_off;

    // per-bit difference of the two operands
    genvar i;
    generate
        for (i = 0; i < DATA_W; i++) begin : g_xor
            assign diff_bits[i] = opnd_a[i] ^ opnd_b[i];
        end
    endgenerate

    // sign-extend and scale the offset to a byte displacement
    always_comb begin
        scaled_off = {{EXT_W{offset[IMM_W-1]}}, offset, 2'b00};
    end

    // taken decision and target address
    always_comb begin
        taken  = is_branch && !block && (diff_bits == '0);
        target = seq_addr + scaled_off;
    end

endmodule

// File: rtl/dh_fetch_regs.sv
// Program counter and fetch/decode pipeline register. hold freezes all of
// them; squash loads a zero instruction word. hold has priority over
// redirect. Synchronous active-low reset.
module dh_fetch_regs #(
    parameter int                ADDR_W   = 32,
    parameter int                INSTR_W  = 32,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hold,
    input  logic               redirect,
    input  logic [ADDR_W-1:0]  redirect_addr,
    input  logic [INSTR_W-1:0] fetched,
    output logic [ADDR_W-1:0]  pc_q,
    output logic [INSTR_W-1:0] instr_q,
    output logic [ADDR_W-1:0]  seq_q
);

    logic [ADDR_W-1:0] pc_inc;

    // sequential fetch address
    always_comb begin
        pc_inc = pc_q + ADDR_W'(4);
    end

    // program counter update
    always_ff @(posedge clk) begin
        if (!rst_n)        pc_q <= RESET_PC;
        else if (hold)     pc_q <= pc_q;
        else if (redirect) pc_q <= redirect_addr;
        else               pc_q <= pc_inc;
    end

    // fetch/decode register capture, hold or squash
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_q <= '0;
            seq_q   <= '0;
        end else if (hold) begin
            instr_q <= instr_q;
            seq_q   <= seq_q;
        end else begin
            instr_q <= redirect ? '0 : fetched;
            seq_q   <= pc_inc;
        end
    end

endmodule

// File: rtl/decode_hazard_ctl.sv
// Decode-stage hazard controller: load-use stall with bubble insertion plus
// early branch-if-equal resolution with predict-not-taken and single-slot
// squash. Operand values come from the register file (forwarding is
// outside this block).
module decode_hazard_ctl
    import decode_hazard_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter int                DATA_W   = 32,
    parameter int                CTRL_W   = 9,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] imem_instr,
    input  logic               ex_mem_read,
    input  logic [RIDX_W-1:0]  ex_dst_reg,
    input  logic [DATA_W-1:0]  src_a_val,
    input  logic [DATA_W-1:0]  src_b_val,
    input  logic [CTRL_W-1:0]  dec_ctrl_in,
    output logic [ADDR_W-1:0]  pc,
    output logic [INSTR_W-1:0] ifid_instr,
    output logic [ADDR_W-1:0]  ifid_seq_pc,
    output logic [CTRL_W-1:0]  id_ctrl_out,
    output logic               stall,
    output logic               flush,
    output logic               br_taken,
    output logic [ADDR_W-1:0]  br_target
);

    instr_fields_t dec_f;
    logic          is_br;

    // split the decode instruction into fields
    always_comb begin
        dec_f = instr_fields_t'(ifid_instr);
        is_br = (dec_f.opcode == OP_BR_EQ);
    end

    dh_load_use_detect #(.RIDX_W(RIDX_W)) u_lu (
        .ld_in_ex (ex_mem_read),
        .ld_dst   (ex_dst_reg),
        .use_a    (dec_f.src_a),
        .use_b    (dec_f.src_b),
        .hazard   (stall)
    );

    dh_branch_resolve #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) u_br (
        .is_branch (is_br),
        .block     (stall),
        .opnd_a    (src_a_val),
        .opnd_b    (src_b_val),
        .seq_addr  (ifid_seq_pc),
        .offset    (dec_f.imm),
        .taken     (br_taken),
        .target    (br_target)
    );

    dh_fetch_regs #(.ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .RESET_PC(RESET_PC)) u_fr (
        .clk           (clk),
        .rst_n         (rst_n),
        .hold          (stall),
        .redirect      (br_taken),
        .redirect_addr (br_target),
        .fetched       (imem_instr),
        .pc_q          (pc),
        .instr_q       (ifid_instr),
        .seq_q         (ifid_seq_pc)
    );

    // squash request and bubble selection
    always_comb begin
        flush       = br_taken;
        id_ctrl_out = stall ? '0 : dec_ctrl_in;
    end

endmodule

// File: rtl/decode_hazard_ctl_chk.sv
// Property checker for decode_hazard_ctl, attached by bind.
module decode_hazard_ctl_chk #(
    parameter int ADDR_W = 32,
    parameter int CTRL_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ex_mem_read,
    input logic [ADDR_W-1:0] pc,
    input logic [31:0]       ifid_instr,
    input logic [CTRL_W-1:0] id_ctrl_out,
    input logic              stall,
    input logic              flush,
    input logic [ADDR_W-1:0] br_target
);

    // R3
    stall_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ex_mem_read);

    // R4
    stall_holds_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    // R4
    stall_holds_instr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(ifid_instr));

    // R5
    bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (id_ctrl_out == '0));

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (ifid_instr == '0));

    // R7
    redirect_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (pc == $past(br_target)));

    // R2
    seq_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !flush) |=> (pc == $past(pc) + ADDR_W'(4)));

    // R9
    stall_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> !flush);

endmodule

bind decode_hazard_ctl decode_hazard_ctl_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ex_mem_read (ex_mem_read),
    .pc          (pc),
    .ifid_instr  (ifid_instr),
    .id_ctrl_out (id_ctrl_out),
    .stall       (stall),
    .flush       (flush),
    .br_target   (br_target)
);

// File: tb/tb_decode_hazard_ctl.sv
module tb_decode_hazard_ctl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] imem_instr;
    logic        ex_mem_read;
    logic [4:0]  ex_dst_reg;
    logic [31:0] src_a_val, src_b_val;
    logic [8:0]  dec_ctrl_in;
    logic [31:0] pc, ifid_instr, ifid_seq_pc, br_target;
    logic [8:0]  id_ctrl_out;
    logic        stall, flush, br_taken;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_pc;

    always #4 clk = ~clk;

    decode_hazard_ctl dut (
        .clk(clk), .rst_n(rst_n), .imem_instr(imem_instr),
        .ex_mem_read(ex_mem_read), .ex_dst_reg(ex_dst_reg),
        .src_a_val(src_a_val), .src_b_val(src_b_val), .dec_ctrl_in(dec_ctrl_in),
        .pc(pc), .ifid_instr(ifid_instr), .ifid_seq_pc(ifid_seq_pc),
        .id_ctrl_out(id_ctrl_out), .stall(stall), .flush(flush),
        .br_taken(br_taken), .br_target(br_target)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // put an instruction into decode with no hazard active (R2)
    task automatic load_instr(input logic [31:0] ins);
        ex_mem_read = 1'b0;
        src_a_val   = 32'h0;
        src_b_val   = 32'h1;
        imem_instr  = ins;
        @(posedge clk); #1;
        exp_pc = exp_pc + 32'd4;
        chk(pc == exp_pc, "R2 pc", pc, exp_pc);
        chk(ifid_instr == ins, "R2 instr", ifid_instr, ins);
        chk(ifid_seq_pc == exp_pc, "R2 seq", ifid_seq_pc, exp_pc);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] offs [8];
        offs[0] = 16'd7;    offs[1] = 16'd0;    offs[2] = 16'hFFFF; offs[3] = 16'hFFFD;
        offs[4] = 16'd100;  offs[5] = 16'h7FFF; offs[6] = 16'h8000; offs[7] = 16'd1;
        rst_n = 1'b0; imem_instr = 32'h0; ex_mem_read = 1'b0; ex_dst_reg = 5'd0;
        src_a_val = 32'h0; src_b_val = 32'h1; dec_ctrl_in = 9'h0;
        repeat (3) @(posedge clk);
        #1;
        chk(pc == 32'h0, "R1 pc", pc, 32'h0);
        chk(ifid_instr == 32'h0, "R1 instr", ifid_instr, 32'h0);
        chk(ifid_seq_pc == 32'h0, "R1 seq", ifid_seq_pc, 32'h0);
        rst_n = 1'b1;
        exp_pc = 32'h0;

        // R3 R4 R5 stall sweep over small register range
        for (int mr = 0; mr < 2; mr++)
            for (int a = 0; a < 4; a++)
                for (int b = 0; b < 4; b++)
                    for (int d = 0; d < 4; d++) begin
                        logic [31:0] ins;
                        logic        es;
                        ins = {6'b000000, 5'(a), 5'(b), 16'h0123};
                        load_instr(ins);
                        ex_mem_read = mr[0];
                        ex_dst_reg  = 5'(d);
                        dec_ctrl_in = 9'h1A5;
                        imem_instr  = 32'hDEADBEEF;
                        #1;
                        es = mr[0] && (d == a || d == b);
                        chk(stall == es, "R3 stall", {31'h0, stall}, {31'h0, es});
                        chk(id_ctrl_out == (es ? 9'h0 : 9'h1A5), "R5 ctrl", {23'h0, id_ctrl_out}, es ? 32'h0 : 32'h1A5);
                        @(posedge clk); #1;
                        if (es) begin
                            chk(pc == exp_pc, "R4 pc hold", pc, exp_pc);
                            chk(ifid_instr == ins, "R4 instr hold", ifid_instr, ins);
                        end else begin
                            exp_pc = exp_pc + 32'd4;
                            chk(pc == exp_pc, "R2 pc step", pc, exp_pc);
                            chk(ifid_instr == 32'hDEADBEEF, "R2 capture", ifid_instr, 32'hDEADBEEF);
                        end
                        ex_mem_read = 1'b0;
                    end

        // R6 R7 R8 branch sweep
        for (int k = 0; k < 8; k++)
            for (int eq = 0; eq < 2; eq++) begin
                logic [31:0] ins, tgt;
                ins = {6'b000100, 5'd1, 5'd2, offs[k]};
                load_instr(ins);
                src_a_val  = 32'h1234_0000 + 32'(k);
                src_b_val  = (eq != 0) ? src_a_val : src_a_val ^ (32'h1 << (k * 4));
                imem_instr = 32'hCAFE0000;
                #1;
                tgt = exp_pc + {{14{offs[k][15]}}, offs[k], 2'b00};
                chk(br_taken == eq[0], "R6 taken", {31'h0, br_taken}, {31'h0, eq[0]});
                chk(flush == eq[0], "R7 flush", {31'h0, flush}, {31'h0, eq[0]});
                if (eq != 0) chk(br_target == tgt, "R6 target", br_target, tgt);
                @(posedge clk); #1;
                if (eq != 0) begin
                    exp_pc = tgt;
                    chk(pc == exp_pc, "R7 redirect", pc, exp_pc);
                    chk(ifid_instr == 32'h0, "R7 squash", ifid_instr, 32'h0);
                end else begin
                    exp_pc = exp_pc + 32'd4;
                    chk(pc == exp_pc, "R8 no redirect", pc, exp_pc);
                    chk(ifid_instr == 32'hCAFE0000, "R8 no squash", ifid_instr, 32'hCAFE0000);
                end
            end

        // R8 other opcode with equal operands
        begin
            logic [31:0] ins;
            ins = {6'b000101, 5'd1, 5'd2, 16'd9};
            load_instr(ins);
            src_a_val = 32'h55; src_b_val = 32'h55; imem_instr = 32'h0;
            #1;
            chk(br_taken == 1'b0, "R8 opcode taken", {31'h0, br_taken}, 32'h0);
            chk(flush == 1'b0, "R8 opcode flush", {31'h0, flush}, 32'h0);
            @(posedge clk); #1;
            exp_pc = exp_pc + 32'd4;
            chk(pc == exp_pc, "R8 opcode pc", pc, exp_pc);
        end

        // R9 stall and branch collide
        begin
            logic [31:0] ins, tgt;
            ins = {6'b000100, 5'd3, 5'd4, 16'd5};
            load_instr(ins);
            tgt = exp_pc + 32'd20;
            ex_mem_read = 1'b1; ex_dst_reg = 5'd4;
            src_a_val = 32'h77; src_b_val = 32'h77; imem_instr = 32'h0;
            #1;
            chk(stall == 1'b1, "R9 stall", {31'h0, stall}, 32'h1);
            chk(flush == 1'b0, "R9 flush low", {31'h0, flush}, 32'h0);
            chk(br_taken == 1'b0, "R9 taken low", {31'h0, br_taken}, 32'h0);
            @(posedge clk); #1;
            chk(pc == exp_pc, "R9 pc hold", pc, exp_pc);
            chk(ifid_instr == ins, "R9 instr hold", ifid_instr, ins);
            ex_mem_read = 1'b0;
            #1;
            chk(flush == 1'b1, "R9 retry flush", {31'h0, flush}, 32'h1);
            @(posedge clk); #1;
            exp_pc = tgt;
            chk(pc == exp_pc, "R9 retry redirect", pc, exp_pc);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule